// File: doc/BRIEF.md
# Selectable-Redundancy Fault-Injection Counter

This block is a free-running binary counter held in three register copies, built so that the effect of single-event upsets can be studied under three redundancy styles. The style is chosen at reset. In whole-block voting, three independent counters run side by side and one majority voter sits on their outputs. In register-only triplication, one next-state path is fed by a voter placed after the three registers. In fully distributed triplication, every copy has its own voter and its own next-state logic. Only the last two styles feed the voted value back into the registers, so only they repair a flipped bit. Whole-block voting can only hide an upset.

A test harness uses three per-copy bit-flip masks and a strobe to emulate upsets. It then watches the voted count, a disagreement flag, a one-cycle first-error pulse and a saturating error counter. An optional supervision mode clears all three copies as soon as the copies start to disagree. This models the policy of resetting the whole system on the first error of any one copy.

Top module: `tmr_count_top`

## Requirements
- R1: While `rst` is high at a clock edge, all three copies and `err_count` are cleared. After that edge `count_out` is 0, `mismatch` is 0 and `first_err` is 0.
- R2: When the copies agree and no strobe is given, `count_out` rises by one after each edge where `cnt_en` is 1. It holds after each edge where `cnt_en` is 0.
- R3: The counter wraps from all ones to zero.
- R4: Whole-block scheme (`scheme_sel` = 2'b00 at reset). An upset in one copy leaves `count_out` correct. `mismatch` stays high on every later cycle until a reset, because no copy is corrected.
- R5: Whole-block scheme. After upsets of the same bit in two different copies, `count_out` shows the wrong value, since voting is a bitwise majority. Only a reset brings back agreement and a zero count.
- R6: Register-only scheme (`scheme_sel` = 2'b01). After an upset in one copy, `mismatch` is high for one cycle. The next edge overwrites all copies with the voted value plus the enable, and `count_out` never shows the upset.
- R7: Distributed scheme (`scheme_sel` = 2'b10 or 2'b11). This scheme repairs a single-copy upset on the next edge, in the same way as R6.
- R8: `mismatch` is high in every cycle where the three copies are not all equal. `first_err` is high only in the first cycle of such a run. `err_count` rises by one at the edge that ends each such first cycle, and does not rise again while the run lasts.
- R9: When `sup_en` is 1 and `first_err` is high at an edge, all three copies are cleared at that edge. Afterwards `count_out` is 0 and `mismatch` is 0, and `err_count` still records the event.
- R10: `err_count` saturates at its maximum value and does not wrap.
- R11: When `upset_stb` is high at an edge, each bit set in a copy's mask takes the inverse of that copy's current value. All other bits take the normal next state.
- R12: `scheme_sel` is sampled only at reset edges. Changing it while counting does not change the repair behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also latches the scheme |
| cnt_en | input | 1 | Count enable |
| scheme_sel | input | 2 | 00 whole-block, 01 register-only, 10/11 distributed |
| sup_en | input | 1 | Clear all copies on the first disagreement |
| upset_a | input | W | Bit-flip mask for copy A |
| upset_b | input | W | Bit-flip mask for copy B |
| upset_c | input | W | Bit-flip mask for copy C |
| upset_stb | input | 1 | Apply the masks at this edge |
| count_out | output | W | Majority-voted count |
| mismatch | output | 1 | Copies are not all equal |
| first_err | output | 1 | First cycle of a disagreement run |
| err_count | output | ECW | Saturating count of disagreement runs |

## Verification
On every cycle, the assertions check the following: the count steps by the enable while the copies agree; a disagreement persists under whole-block voting and clears within one edge under the repairing schemes; the first-error pulse lasts one cycle; the error counter takes one step per pulse and holds at saturation; supervision clears the copies; and the latched scheme stays stable. Some effects can only be shown by the bench's scenarios, because they depend on chosen injection patterns. These are the wrong output after two same-bit upsets, flushing by reset, the bit-exact precedence of flipped bits over the count update, wrap-around, and the fact that a mid-run change of `scheme_sel` has no effect.

// File: rtl/tmr_count_pkg.sv
package tmr_count_pkg;
  typedef enum logic [1:0] {
    SCH_BLOCK = 2'b00,
    SCH_LOCAL = 2'b01,
    SCH_DIST  = 2'b10
  } scheme_e;

  function automatic scheme_e decode_scheme(input logic [1:0] sel);
    case (sel)
      2'b00:   return SCH_BLOCK;
      2'b01:   return SCH_LOCAL;
      default: return SCH_DIST;
    endcase
  endfunction
endpackage

// File: rtl/tmr_count_voter.sv
module tmr_count_voter #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] y
);
  assign y = (a & b) | (a & c) | (b & c);
endmodule

// File: rtl/tmr_count_step.sv
module tmr_count_step #(
  parameter int W = 16
) (
  input  logic [W-1:0] cur,
  input  logic         en,
  output logic [W-1:0] nxt
);
  assign nxt = cur + W'(en);
endmodule

// File: rtl/tmr_count_watch.sv
module tmr_count_watch #(
  parameter int W   = 16,
  parameter int ECW = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [2:0][W-1:0]   cp,
  output logic                mismatch,
  output logic                first_err,
  output logic [ECW-1:0]      err_count
);
  localparam logic [ECW-1:0] ERR_MAX = '1;

  logic           prev_q;
  logic [ECW-1:0] err_q;

  assign mismatch  = (cp[0] != cp[1]) || (cp[1] != cp[2]);
  assign first_err = mismatch & ~prev_q;
  assign err_count = err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      err_q  <= '0;
    end else begin
      prev_q <= mismatch;
      if (first_err && err_q != ERR_MAX) err_q <= err_q + 1'b1;
    end
  end
endmodule

// File: rtl/tmr_count_top.sv
module tmr_count_top
  import tmr_count_pkg::*;
#(
  parameter int W   = 16,
  parameter int ECW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cnt_en,
  input  logic [1:0]     scheme_sel,
  input  logic           sup_en,
  input  logic [W-1:0]   upset_a,
  input  logic [W-1:0]   upset_b,
  input  logic [W-1:0]   upset_c,
  input  logic           upset_stb,
  output logic [W-1:0]   count_out,
  output logic           mismatch,
  output logic           first_err,
  output logic [ECW-1:0] err_count
);
  localparam int NCP = 3;

  scheme_e              mode_q;
  logic [NCP-1:0][W-1:0] cp_q;
  logic [NCP-1:0][W-1:0] vote;
  logic [NCP-1:0][W-1:0] src;
  logic [NCP-1:0][W-1:0] nxt;
  logic [NCP-1:0][W-1:0] dnext;
  logic [NCP-1:0][W-1:0] msk;

  assign msk = {upset_c, upset_b, upset_a};

  for (genvar i = 0; i < NCP; i++) begin : g_copy
    tmr_count_voter #(.W(W)) u_vote (
      .a(cp_q[0]), .b(cp_q[1]), .c(cp_q[2]), .y(vote[i])
    );

    // Whole-block copies step from their own register; the repairing
    // schemes step from a voted value (shared voter for register-only).
    always_comb begin
      case (mode_q)
        SCH_BLOCK: src[i] = cp_q[i];
        SCH_LOCAL: src[i] = vote[0];
        default:   src[i] = vote[i];
      endcase
    end

    tmr_count_step #(.W(W)) u_step (
      .cur(src[i]), .en(cnt_en), .nxt(nxt[i])
    );

    // Register-only triplication: one next-state path drives all registers.
    assign dnext[i] = (mode_q == SCH_LOCAL) ? nxt[0] : nxt[i];
  end

  assign count_out = vote[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cp_q   <= '0;
      mode_q <= decode_scheme(scheme_sel);
    end else if (sup_en && first_err) begin
      cp_q <= '0;
    end else begin
      for (int i = 0; i < NCP; i++) begin
        if (upset_stb)
          cp_q[i] <= (dnext[i] & ~msk[i]) | (~cp_q[i] & msk[i]);
        else
          cp_q[i] <= dnext[i];
      end
    end
  end

  tmr_count_watch #(.W(W), .ECW(ECW)) u_watch (
    .clk(clk), .rst(rst), .cp(cp_q),
    .mismatch(mismatch), .first_err(first_err), .err_count(err_count)
  );
endmodule

// File: rtl/tmr_count_check.sv
module tmr_count_check
  import tmr_count_pkg::*;
#(
  parameter int W   = 16,
  parameter int ECW = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           cnt_en,
  input logic           sup_en,
  input logic           upset_stb,
  input logic [W-1:0]   count_out,
  input logic           mismatch,
  input logic           first_err,
  input logic [ECW-1:0] err_count,
  input scheme_e        mode_q
);
  localparam logic [ECW-1:0] ERR_MAX = '1;

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (count_out == '0 && !mismatch && err_count == '0));

  p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
    (!mismatch && !upset_stb) |=> (count_out == W'($past(count_out) + W'($past(cnt_en)))));

  p_block_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (mode_q == SCH_BLOCK && mismatch && !upset_stb && !(sup_en && first_err)) |=> mismatch);

  // covers R6 and R7
  p_fix_next_r6: assert property (@(posedge clk) disable iff (rst)
    (mode_q != SCH_BLOCK && mismatch && !upset_stb) |=> !mismatch);

  p_first_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    first_err |=> !first_err);

  p_err_step_r8: assert property (@(posedge clk) disable iff (rst)
    (first_err && err_count != ERR_MAX) |=> (ECW'(err_count - $past(err_count)) == ECW'(1)));

  p_super_flush_r9: assert property (@(posedge clk) disable iff (rst)
    (sup_en && first_err) |=> (count_out == '0 && !mismatch));

  p_err_sat_r10: assert property (@(posedge clk) disable iff (rst)
    (err_count == ERR_MAX) |=> (err_count == ERR_MAX));

  p_mode_lock_r12: assert property (@(posedge clk) disable iff (rst)
    !rst |=> $stable(mode_q));
endmodule

bind tmr_count_top tmr_count_check #(.W(W), .ECW(ECW)) u_check (
  .clk(clk), .rst(rst), .cnt_en(cnt_en), .sup_en(sup_en),
  .upset_stb(upset_stb), .count_out(count_out), .mismatch(mismatch),
  .first_err(first_err), .err_count(err_count), .mode_q(mode_q)
);

// File: tb/tmr_count_top_bench.sv
module tmr_count_top_bench;
  localparam int W          = 8;
  localparam int ECW        = 4;
  localparam int CLK_PERIOD = 10;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           cnt_en = 1'b0;
  logic [1:0]     scheme_sel = 2'b00;
  logic           sup_en = 1'b0;
  logic [W-1:0]   upset_a = '0;
  logic [W-1:0]   upset_b = '0;
  logic [W-1:0]   upset_c = '0;
  logic           upset_stb = 1'b0;
  logic [W-1:0]   count_out;
  logic           mismatch;
  logic           first_err;
  logic [ECW-1:0] err_count;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_count_top #(.W(W), .ECW(ECW)) u_tmr_count_top (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .scheme_sel(scheme_sel),
    .sup_en(sup_en), .upset_a(upset_a), .upset_b(upset_b), .upset_c(upset_c),
    .upset_stb(upset_stb), .count_out(count_out), .mismatch(mismatch),
    .first_err(first_err), .err_count(err_count)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] sch, input logic sup);
    rst = 1'b1; scheme_sel = sch; sup_en = sup; cnt_en = 1'b0;
    upset_stb = 1'b0; upset_a = '0; upset_b = '0; upset_c = '0;
    tick();
    rst = 1'b0;
    check("R1 count after reset", count_out, 0);
    check("R1 mismatch after reset", mismatch, 0);
    check("R1 first_err after reset", first_err, 0);
    check("R1 err_count after reset", err_count, 0);
  endtask

  task automatic run(input int n, input logic en);
    cnt_en = en;
    for (int k = 0; k < n; k++) tick();
    cnt_en = 1'b0;
  endtask

  task automatic inject(input logic [W-1:0] ma, input logic [W-1:0] mb,
                        input logic [W-1:0] mc, input logic en);
    upset_a = ma; upset_b = mb; upset_c = mc; upset_stb = 1'b1; cnt_en = en;
    tick();
    upset_stb = 1'b0; upset_a = '0; upset_b = '0; upset_c = '0; cnt_en = 1'b0;
  endtask

  task automatic t_count();
    do_reset(2'b01, 1'b0);
    run(10, 1'b1);
    check("R2 count after 10 enables", count_out, 10);
    run(3, 1'b0);
    check("R2 hold with enable low", count_out, 10);
  endtask

  task automatic t_wrap();
    do_reset(2'b10, 1'b0);
    run(255, 1'b1);
    check("R3 count at all ones", count_out, 255);
    run(1, 1'b1);
    check("R3 wrap to zero", count_out, 0);
  endtask

  task automatic t_block();
    do_reset(2'b00, 1'b0);
    run(5, 1'b1);
    inject(8'h10, 8'h00, 8'h00, 1'b0);
    check("R4 single upset masked", count_out, 5);
    check("R8 mismatch raised", mismatch, 1);
    check("R8 first_err pulse", first_err, 1);
    check("R8 err_count before edge", err_count, 0);
    tick();
    check("R4 disagreement persists", mismatch, 1);
    check("R8 first_err one cycle", first_err, 0);
    check("R8 err_count after pulse", err_count, 1);
    run(3, 1'b1);
    check("R4 masked while counting", count_out, 8);
    check("R4 still disagree", mismatch, 1);
    check("R8 no recount in same run", err_count, 1);
    inject(8'h00, 8'h10, 8'h00, 1'b0);
    check("R5 two-copy upset wrong output", count_out, 8'h18);
    do_reset(2'b00, 1'b0);
    check("R5 reset flushes copies", count_out, 0);
  endtask

  task automatic t_repair(input logic [1:0] sch, input string tag);
    do_reset(sch, 1'b0);
    run(5, 1'b1);
    inject(8'h10, 8'h00, 8'h00, 1'b0);
    check({tag, " upset hidden"}, count_out, 5);
    check({tag, " mismatch for one cycle"}, mismatch, 1);
    tick();
    check({tag, " repaired next edge"}, mismatch, 0);
    check({tag, " output unchanged"}, count_out, 5);
    check({tag, " err_count one"}, err_count, 1);
    inject(8'h00, 8'h00, 8'h80, 1'b1);
    check({tag, " upset while counting"}, count_out, 6);
    check({tag, " mismatch on copy C"}, mismatch, 1);
    run(1, 1'b1);
    check({tag, " repaired and counted"}, count_out, 7);
    check({tag, " agree again"}, mismatch, 0);
    check({tag, " err_count two"}, err_count, 2);
  endtask

  task automatic t_precedence();
    do_reset(2'b00, 1'b0);
    run(5, 1'b1);
    inject(8'h01, 8'h01, 8'h00, 1'b1);
    check("R11 flipped bit beats update", count_out, 6);
    check("R11 copies agree", mismatch, 0);
  endtask

  task automatic t_super();
    do_reset(2'b00, 1'b1);
    run(5, 1'b1);
    inject(8'h10, 8'h00, 8'h00, 1'b0);
    check("R9 first_err seen", first_err, 1);
    tick();
    check("R9 copies cleared", count_out, 0);
    check("R9 mismatch cleared", mismatch, 0);
    check("R9 event recorded", err_count, 1);
  endtask

  task automatic t_saturate();
    do_reset(2'b01, 1'b0);
    for (int k = 0; k < 17; k++) begin
      inject(8'h01, 8'h00, 8'h00, 1'b0);
      tick();
    end
    check("R10 err_count saturated", err_count, 15);
  endtask

  task automatic t_mode_lock();
    do_reset(2'b00, 1'b0);
    scheme_sel = 2'b01;
    inject(8'h01, 8'h00, 8'h00, 1'b0);
    tick();
    tick();
    check("R12 scheme held from reset", mismatch, 1);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_count();
    t_wrap();
    t_block();
    t_repair(2'b01, "R6");
    t_repair(2'b10, "R7");
    t_repair(2'b11, "R7");
    t_precedence();
    t_super();
    t_saturate();
    t_mode_lock();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule